// File: doc/BRIEF.md
# Fractional PLL Reprogramming Sequencer

This block is the hardware state machine that sits between a command source and a fractional-N PLL. On a reprogram request it takes the PLL off the clock path and powers it down, writes new divider settings, waits for the analog loop to settle, powers it up and waits for lock. It then puts the output back on the path and compares the numerator the PLL reports with the one that was requested. The lock wait has a bound. If lock is never seen, the operation ends with an error and the output stays off.

Two further commands handle cold start and shutdown. Prepare powers the PLL up with the bypass mux selected and waits for lock before releasing bypass. It does nothing if the PLL is already powered. Unprepare removes power only. All delays are counted in clock cycles, derived from a clock frequency parameter given in MHz. The analog PLL is not part of this block: the control word, the three programmed registers and the status word are its interface to it.

Top module: `fpll_reprog_seq`

## Requirements
- R1: After reset the control word is 000, the three programmed registers are zero, and busy, done, lock_timeout and mfn_mismatch are all low.
- R2: A reprogram changes the control word one bit per cycle. It first clears output enable (bit 1), then power-up (bit 0), then bypass select (bit 2), and any bit that is already clear produces no change. Across all operations, no two control bits ever change in the same cycle.
- R3: A reprogram writes the divider register as multiplier in bits 24:16, reference divider in bits 15:13 and output divider in bits 7:0, with all other bits zero. The numerator register holds the numerator in bits 31:2 and zero in bits 1:0. The denominator register holds the denominator in bits 29:0 and zero in bits 31:30. These registers change only while power-up is clear.
- R4: Power-up rises no earlier than SETTLE_CYC = CLK_MHZ*SETTLE_US cycles after the registers take their new values, and no later than SETTLE_CYC+4 cycles after.
- R5: After power-up the sequencer waits for status bit 0 (lock). On a reprogram, output enable is set only after lock has been seen.
- R6: If lock is not seen within LOCK_CYC = CLK_MHZ*LOCK_US cycles of power-up (plus at most 4 cycles), the operation ends with done and lock_timeout high. On a reprogram the control word is then 001, with output off.
- R7: After a reprogram sets output enable, status bits 31:2 are compared with the requested numerator. A difference sets mfn_mismatch with done, while lock_timeout stays low and the final control word is still 011.
- R8: Prepare with power-up already set gives done in the cycle after acceptance and leaves the control word unchanged.
- R9: A cold prepare sets bypass, then power-up, then output enable (skipping any bit already set). It then waits for lock and clears bypass at the end. On a lock timeout it ends with lock_timeout and leaves the control word at 111.
- R10: Unprepare clears only power-up and pulses done. The other two control bits are unchanged.
- R11: Any command that arrives while busy is high is ignored. The operation in progress finishes with the fields that were latched when it was accepted.
- R12: done is high for exactly one cycle. lock_timeout and mfn_mismatch are cleared in the cycle after a new command is accepted.
- R13: When several commands are requested in the same idle cycle, reprogram wins over prepare, and prepare wins over unprepare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_reprog | input | 1 | Reprogram request strobe |
| req_prepare | input | 1 | Prepare (cold start) request strobe |
| req_unprepare | input | 1 | Unprepare (power down) request strobe |
| set_mfi | input | 9 | Requested integer multiplier |
| set_mfn | input | 30 | Requested fractional numerator |
| set_mfd | input | 30 | Requested fractional denominator |
| set_rdiv | input | 3 | Requested reference divider |
| set_odiv | input | 8 | Requested output divider |
| pll_status | input | 32 | PLL status: bit 0 lock, bits 31:2 numerator readback |
| pll_ctrl | output | 3 | Control word: bit 2 bypass, bit 1 output enable, bit 0 power-up |
| div_reg | output | 32 | Programmed divider register |
| num_reg | output | 32 | Programmed numerator register |
| den_reg | output | 32 | Programmed denominator register |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| lock_timeout | output | 1 | Last operation ended without lock |
| mfn_mismatch | output | 1 | Last reprogram read back a different numerator |

## Verification
Two situations are hard to reach from the ports. The first is a reprogram that must show all three shutdown steps in order, which needs a starting control word of 111. Normal operation never leaves that word, so the stimulus first runs a cold prepare with the lock model held off. That prepare times out with bypass, output and power all set, and the table of reprogram vectors then starts from there. The second is a command that arrives mid-sequence. The bench injects reprogram, prepare and unprepare together, with different fields, partway through the settle wait. It then checks that the finished registers and control word still match the first request.

// File: rtl/fpll_pkg.sv
package fpll_pkg;

    // control word bit positions (decoded by the PLL)
    localparam int CB_PU  = 0;
    localparam int CB_OE  = 1;
    localparam int CB_BYP = 2;

    // register field positions (decoded by the PLL)
    localparam int MFI_LSB  = 16;
    localparam int RDIV_LSB = 13;
    localparam int ODIV_LSB = 0;
    localparam int NUM_LSB  = 2;
    localparam int DEN_LSB  = 0;
    localparam int STAT_LOCK = 0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_R_OUTOFF,
        S_R_PWROFF,
        S_R_BYPOFF,
        S_R_PROG,
        S_R_SETTLE,
        S_R_PWRON,
        S_R_LOCK,
        S_R_OUTON,
        S_R_CHECK,
        S_P_BYPON,
        S_P_PWRON,
        S_P_OUTON,
        S_P_LOCK,
        S_P_BYPOFF
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_REPROG,
        OP_PREP,
        OP_UNPREP
    } op_kind_e;

endpackage

// File: rtl/fpll_field_pack.sv
module fpll_field_pack #(
    parameter int REG_W  = 32,
    parameter int MFI_W  = 9,
    parameter int RDIV_W = 3,
    parameter int ODIV_W = 8,
    parameter int MFN_W  = 30,
    parameter int MFD_W  = 30
) (
    input  logic [MFI_W-1:0]  mfi,
    input  logic [RDIV_W-1:0] rdiv,
    input  logic [ODIV_W-1:0] odiv,
    input  logic [MFN_W-1:0]  mfn,
    input  logic [MFD_W-1:0]  mfd,
    output logic [REG_W-1:0]  div_word,
    output logic [REG_W-1:0]  num_word,
    output logic [REG_W-1:0]  den_word
);
    import fpll_pkg::*;

    always_comb begin
        div_word = '0;
        div_word[MFI_LSB  +: MFI_W]  = mfi;
        div_word[RDIV_LSB +: RDIV_W] = rdiv;
        div_word[ODIV_LSB +: ODIV_W] = odiv;
        num_word = '0;
        num_word[NUM_LSB +: MFN_W] = mfn;
        den_word = '0;
        den_word[DEN_LSB +: MFD_W] = mfd;
    end

endmodule

// File: rtl/fpll_cycle_timer.sv
module fpll_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/fpll_seq_core.sv
module fpll_seq_core #(
    parameter int REG_W      = 32,
    parameter int MFN_W      = 30,
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 625,
    parameter int LOCK_CYC   = 25000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_reprog,
    input  logic             cmd_prepare,
    input  logic             cmd_unprepare,
    input  logic [REG_W-1:0] new_div,
    input  logic [REG_W-1:0] new_num,
    input  logic [REG_W-1:0] new_den,
    input  logic [MFN_W-1:0] new_mfn,
    input  logic [REG_W-1:0] status,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic [2:0]       ctrl,
    output logic [REG_W-1:0] div_word,
    output logic [REG_W-1:0] num_word,
    output logic [REG_W-1:0] den_word,
    output logic             busy,
    output logic             done,
    output logic             timeout_err,
    output logic             mismatch
);
    import fpll_pkg::*;

    typedef struct packed {
        seq_state_e       st;
        op_kind_e         op;
        logic [2:0]       ctrl;
        logic [REG_W-1:0] div;
        logic [REG_W-1:0] num;
        logic [REG_W-1:0] den;
        logic [REG_W-1:0] div_req;
        logic [REG_W-1:0] num_req;
        logic [REG_W-1:0] den_req;
        logic [MFN_W-1:0] mfn_req;
        logic             lock_seen;
        logic             done;
        logic             err;
        logic             mm;
    } core_s;

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] LOCK_LD   = CNT_W'(LOCK_CYC);

    core_s q, d;
    logic  locked;
    logic  rb_differs;

    assign locked     = status[STAT_LOCK];
    assign rb_differs = (status[NUM_LSB +: MFN_W] != q.mfn_req);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.st)
            S_IDLE: begin
                if (cmd_reprog || cmd_prepare || cmd_unprepare) begin
                    d.err       = 1'b0;
                    d.mm        = 1'b0;
                    d.lock_seen = 1'b0;
                end
                if (cmd_reprog) begin
                    d.op      = OP_REPROG;
                    d.div_req = new_div;
                    d.num_req = new_num;
                    d.den_req = new_den;
                    d.mfn_req = new_mfn;
                    d.st      = S_R_OUTOFF;
                end else if (cmd_prepare) begin
                    d.op = OP_PREP;
                    if (q.ctrl[CB_PU]) d.done = 1'b1;
                    else               d.st   = S_P_BYPON;
                end else if (cmd_unprepare) begin
                    d.op           = OP_UNPREP;
                    d.ctrl[CB_PU]  = 1'b0;
                    d.done         = 1'b1;
                end
            end
            S_R_OUTOFF: begin
                d.ctrl[CB_OE] = 1'b0;
                d.st          = S_R_PWROFF;
            end
            S_R_PWROFF: begin
                d.ctrl[CB_PU] = 1'b0;
                d.st          = S_R_BYPOFF;
            end
            S_R_BYPOFF: begin
                d.ctrl[CB_BYP] = 1'b0;
                d.st           = S_R_PROG;
            end
            S_R_PROG: begin
                d.div    = q.div_req;
                d.num    = q.num_req;
                d.den    = q.den_req;
                tmr_load = 1'b1;
                tmr_val  = SETTLE_LD;
                d.st     = S_R_SETTLE;
            end
            S_R_SETTLE: begin
                if (tmr_expired) d.st = S_R_PWRON;
            end
            S_R_PWRON: begin
                d.ctrl[CB_PU] = 1'b1;
                tmr_load      = 1'b1;
                tmr_val       = LOCK_LD;
                d.st          = S_R_LOCK;
            end
            S_R_LOCK: begin
                if (locked) begin
                    d.lock_seen = 1'b1;
                    d.st        = S_R_OUTON;
                end else if (tmr_expired) begin
                    d.err  = 1'b1;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_R_OUTON: begin
                d.ctrl[CB_OE] = 1'b1;
                d.st          = S_R_CHECK;
            end
            S_R_CHECK: begin
                d.mm   = rb_differs;
                d.done = 1'b1;
                d.st   = S_IDLE;
            end
            S_P_BYPON: begin
                d.ctrl[CB_BYP] = 1'b1;
                d.st           = S_P_PWRON;
            end
            S_P_PWRON: begin
                d.ctrl[CB_PU] = 1'b1;
                d.st          = S_P_OUTON;
            end
            S_P_OUTON: begin
                d.ctrl[CB_OE] = 1'b1;
                tmr_load      = 1'b1;
                tmr_val       = LOCK_LD;
                d.st          = S_P_LOCK;
            end
            S_P_LOCK: begin
                if (locked) begin
                    d.lock_seen = 1'b1;
                    d.st        = S_P_BYPOFF;
                end else if (tmr_expired) begin
                    d.err  = 1'b1;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_P_BYPOFF: begin
                d.ctrl[CB_BYP] = 1'b0;
                d.done         = 1'b1;
                d.st           = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, op: OP_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign ctrl        = q.ctrl;
    assign div_word    = q.div;
    assign num_word    = q.num;
    assign den_word    = q.den;
    assign busy        = (q.st != S_IDLE);
    assign done        = q.done;
    assign timeout_err = q.err;
    assign mismatch    = q.mm;

    // R2: never more than one control bit moves per cycle
    a_r2_one_ctrl_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.ctrl ^ $past(q.ctrl)) <= 1);

    // R2: output is already off when a reprogram removes power
    a_r2_oe_off_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op == OP_REPROG && $fell(q.ctrl[CB_PU])) |-> !q.ctrl[CB_OE]);

    // R3: programmed registers only move while powered down
    a_r3_regs_while_down: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.div) |-> !q.ctrl[CB_PU]);

    // R5: reprogram enables the output only after lock was seen
    a_r5_oe_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op == OP_REPROG && $rose(q.ctrl[CB_OE])) |-> q.lock_seen);

    // R6: a reprogram timeout leaves the output disabled
    a_r6_timeout_out_off: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op == OP_REPROG && $rose(q.err)) |-> !q.ctrl[CB_OE]);

    // R10: unprepare touches only power-up
    a_r10_unprep_pu_only: assert property (@(posedge clk) disable iff (!rst_n)
        (q.op == OP_UNPREP && q.done) |-> (!q.ctrl[CB_PU] && $stable(q.ctrl[CB_OE]) && $stable(q.ctrl[CB_BYP])));

    // R11: latched request does not move while busy
    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.div_req) && $stable(q.mfn_req)));

    // R12: done is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

endmodule

// File: rtl/fpll_reprog_seq.sv
module fpll_reprog_seq #(
    parameter int CLK_MHZ   = 125,
    parameter int SETTLE_US = 5,
    parameter int LOCK_US   = 200,
    parameter int MFI_W     = 9,
    parameter int RDIV_W    = 3,
    parameter int ODIV_W    = 8,
    parameter int MFN_W     = 30,
    parameter int MFD_W     = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reprog,
    input  logic              req_prepare,
    input  logic              req_unprepare,
    input  logic [MFI_W-1:0]  set_mfi,
    input  logic [MFN_W-1:0]  set_mfn,
    input  logic [MFD_W-1:0]  set_mfd,
    input  logic [RDIV_W-1:0] set_rdiv,
    input  logic [ODIV_W-1:0] set_odiv,
    input  logic [31:0]       pll_status,
    output logic [2:0]        pll_ctrl,
    output logic [31:0]       div_reg,
    output logic [31:0]       num_reg,
    output logic [31:0]       den_reg,
    output logic              busy,
    output logic              done,
    output logic              lock_timeout,
    output logic              mfn_mismatch
);
    localparam int REG_W      = 32;
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int LOCK_CYC   = CLK_MHZ * LOCK_US;
    localparam int MAX_CYC    = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    logic [REG_W-1:0] pk_div, pk_num, pk_den;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    fpll_field_pack #(
        .REG_W(REG_W), .MFI_W(MFI_W), .RDIV_W(RDIV_W),
        .ODIV_W(ODIV_W), .MFN_W(MFN_W), .MFD_W(MFD_W)
    ) u_pack (
        .mfi(set_mfi), .rdiv(set_rdiv), .odiv(set_odiv),
        .mfn(set_mfn), .mfd(set_mfd),
        .div_word(pk_div), .num_word(pk_num), .den_word(pk_den)
    );

    fpll_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    fpll_seq_core #(
        .REG_W(REG_W), .MFN_W(MFN_W), .CNT_W(CNT_W),
        .SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .cmd_reprog(req_reprog), .cmd_prepare(req_prepare),
        .cmd_unprepare(req_unprepare),
        .new_div(pk_div), .new_num(pk_num), .new_den(pk_den),
        .new_mfn(set_mfn), .status(pll_status),
        .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .ctrl(pll_ctrl), .div_word(div_reg), .num_word(num_reg),
        .den_word(den_reg), .busy(busy), .done(done),
        .timeout_err(lock_timeout), .mismatch(mfn_mismatch)
    );

endmodule

// File: tb/fpll_reprog_seq_tb.sv
`timescale 1ns/1ps
module fpll_reprog_seq_tb;

    localparam int CLK_MHZ  = 125;
    localparam int SETTLE_C = CLK_MHZ * 5;
    localparam int LOCK_C   = CLK_MHZ * 200;
    localparam int LOCK_LAT = 40;
    localparam int OP_LIMIT = 40000;

    typedef struct packed {
        logic [8:0]  mfi;
        logic [29:0] mfn;
        logic [29:0] mfd;
        logic [2:0]  rdiv;
        logic [7:0]  odiv;
        logic        lock_ok;
        logic        rb_bad;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VEC [NV] = '{
        '{9'd70,  30'd0,  30'd1,   3'd0, 8'd3, 1'b1, 1'b0},
        '{9'd81,  30'd92, 30'd100, 3'd0, 8'd5, 1'b0, 1'b0},
        '{9'd198, 30'd7,  30'd50,  3'd1, 8'd8, 1'b1, 1'b1},
        '{9'd121, 30'd0,  30'd1,   3'd2, 8'd6, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_reprog = 1'b0, req_prepare = 1'b0, req_unprepare = 1'b0;
    logic [8:0]  set_mfi = '0;
    logic [29:0] set_mfn = '0;
    logic [29:0] set_mfd = '0;
    logic [2:0]  set_rdiv = '0;
    logic [7:0]  set_odiv = '0;
    logic [31:0] pll_status;
    logic [2:0]  pll_ctrl;
    logic [31:0] div_reg, num_reg, den_reg;
    logic busy, done, lock_timeout, mfn_mismatch;

    always #4 clk = ~clk;

    fpll_reprog_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_reprog(req_reprog), .req_prepare(req_prepare), .req_unprepare(req_unprepare),
        .set_mfi(set_mfi), .set_mfn(set_mfn), .set_mfd(set_mfd),
        .set_rdiv(set_rdiv), .set_odiv(set_odiv), .pll_status(pll_status),
        .pll_ctrl(pll_ctrl), .div_reg(div_reg), .num_reg(num_reg), .den_reg(den_reg),
        .busy(busy), .done(done), .lock_timeout(lock_timeout), .mfn_mismatch(mfn_mismatch)
    );

    // lock model standing in for the analog loop
    logic        lock_en = 1'b0;
    logic        lock_q = 1'b0;
    int          lk_cnt = 0;
    logic [29:0] rb_mfn = '0;
    assign pll_status = {rb_mfn, 1'b0, lock_q};

    always @(negedge clk) begin
        if (!pll_ctrl[0]) begin
            lk_cnt <= 0;
            lock_q <= 1'b0;
        end else begin
            if (lk_cnt < LOCK_LAT) lk_cnt <= lk_cnt + 1;
            lock_q <= lock_en && (lk_cnt >= LOCK_LAT);
        end
    end

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // observation of one operation
    int   ev [16];
    int   nev;
    int   ex [16];
    int   nex;
    int   t_div, t_pu, t_done;
    logic got_err, got_mm, flags_at1;

    task automatic run_op(input int kind, input vec_t v, input int inject_at, input vec_t alt);
        logic [2:0]  prev;
        logic [31:0] prevdiv;
        int cyc;
        lock_en = v.lock_ok;
        rb_mfn  = v.rb_bad ? (v.mfn ^ 30'd1) : v.mfn;
        @(negedge clk);
        set_mfi = v.mfi; set_mfn = v.mfn; set_mfd = v.mfd;
        set_rdiv = v.rdiv; set_odiv = v.odiv;
        req_reprog    = (kind == 0) || (kind == 3);
        req_prepare   = (kind == 1) || (kind == 3);
        req_unprepare = (kind == 2) || (kind == 3);
        prev = pll_ctrl; prevdiv = div_reg;
        nev = 0; t_div = -1; t_pu = -1; t_done = -1; cyc = 0;
        got_err = 1'b0; got_mm = 1'b0; flags_at1 = 1'b0;
        while (t_done < 0 && cyc < OP_LIMIT) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                req_reprog = 1'b0; req_prepare = 1'b0; req_unprepare = 1'b0;
                flags_at1 = lock_timeout | mfn_mismatch;
            end
            if (cyc == inject_at) begin
                set_mfi = alt.mfi; set_mfn = alt.mfn; set_mfd = alt.mfd;
                set_rdiv = alt.rdiv; set_odiv = alt.odiv;
                req_reprog = 1'b1; req_prepare = 1'b1; req_unprepare = 1'b1;
            end
            if (cyc == inject_at + 1) begin
                req_reprog = 1'b0; req_prepare = 1'b0; req_unprepare = 1'b0;
            end
            for (int b = 0; b < 3; b++) begin
                if (pll_ctrl[b] != prev[b]) begin
                    if (nev < 16) ev[nev] = b * 2 + int'(pll_ctrl[b]);
                    nev++;
                    if (b == 0 && pll_ctrl[0]) t_pu = cyc;
                end
            end
            if (div_reg != prevdiv && t_div < 0) t_div = cyc;
            prev = pll_ctrl; prevdiv = div_reg;
            if (done) begin
                t_done = cyc; got_err = lock_timeout; got_mm = mfn_mismatch;
            end
        end
        chk(t_done >= 0, "R12 operation completes with done", 64'(cyc), 64'(OP_LIMIT));
        chk(flags_at1 == 1'b0, "R12 flags cleared on accept", 64'(flags_at1), 0);
        @(negedge clk);
        chk(done == 1'b0, "R12 done lasts one cycle", 64'(done), 0);
    endtask

    // event codes: bit*2 + new value (pu=0, oe=1, byp=2)
    task automatic exp_reprog(input logic [2:0] s, input bit lk);
        nex = 0;
        if (s[1]) begin ex[nex] = 2; nex++; end
        if (s[0]) begin ex[nex] = 0; nex++; end
        if (s[2]) begin ex[nex] = 4; nex++; end
        ex[nex] = 1; nex++;
        if (lk) begin ex[nex] = 3; nex++; end
    endtask

    task automatic exp_prep(input logic [2:0] s, input bit lk);
        nex = 0;
        if (!s[2]) begin ex[nex] = 5; nex++; end
        if (!s[0]) begin ex[nex] = 1; nex++; end
        if (!s[1]) begin ex[nex] = 3; nex++; end
        if (lk) begin ex[nex] = 4; nex++; end
    endtask

    task automatic cmp_events(input string req);
        bit ok;
        logic [63:0] a, e;
        ok = (nev == nex);
        a = '0; e = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < nev && i < 16) a = {a[59:0], 4'(ev[i])};
            if (i < nex) e = {e[59:0], 4'(ex[i])};
            if (ok && i < nex && ev[i] != ex[i]) ok = 1'b0;
        end
        chk(ok, req, a, e);
    endtask

    task automatic chk_regs(input vec_t v, input string req);
        chk(div_reg == {7'd0, v.mfi, v.rdiv, 5'd0, v.odiv}, req, 64'(div_reg),
            64'({7'd0, v.mfi, v.rdiv, 5'd0, v.odiv}));
        chk(num_reg == {v.mfn, 2'b00}, req, 64'(num_reg), 64'({v.mfn, 2'b00}));
        chk(den_reg == {2'b00, v.mfd}, req, 64'(den_reg), 64'({2'b00, v.mfd}));
    endtask

    initial begin
        logic [2:0] s;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pll_ctrl == 3'b000 && div_reg == 0 && num_reg == 0 && den_reg == 0,
            "R1 reset outputs", 64'({pll_ctrl, div_reg}), 0);
        chk({busy, done, lock_timeout, mfn_mismatch} == 4'b0000, "R1 reset flags",
            64'({busy, done, lock_timeout, mfn_mismatch}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9/R6: cold prepare with no lock -> times out, leaves 111
        s = pll_ctrl;
        run_op(1, '{9'd0, 30'd0, 30'd0, 3'd0, 8'd0, 1'b0, 1'b0}, -1, '0);
        exp_prep(s, 1'b0);
        cmp_events("R9 cold prepare order");
        chk(got_err == 1'b1 && pll_ctrl == 3'b111, "R9 prepare timeout state",
            64'({got_err, pll_ctrl}), 64'({1'b1, 3'b111}));
        chk(t_done - t_pu >= LOCK_C && t_done - t_pu <= LOCK_C + 4, "R6 prepare lock window",
            64'(t_done - t_pu), 64'(LOCK_C));

        // vector table of reprograms
        for (int i = 0; i < NV; i++) begin
            s = pll_ctrl;
            run_op(0, VEC[i], -1, '0);
            exp_reprog(s, VEC[i].lock_ok);
            cmp_events($sformatf("R2 R5 reprogram order vec%0d", i));
            chk_regs(VEC[i], $sformatf("R3 fields vec%0d", i));
            chk(t_pu - t_div >= SETTLE_C && t_pu - t_div <= SETTLE_C + 4,
                $sformatf("R4 settle gap vec%0d", i), 64'(t_pu - t_div), 64'(SETTLE_C));
            if (VEC[i].lock_ok) begin
                chk(pll_ctrl == 3'b011 && got_err == 1'b0, $sformatf("R5 locked end vec%0d", i),
                    64'({got_err, pll_ctrl}), 64'(3'b011));
                chk(got_mm == VEC[i].rb_bad, $sformatf("R7 readback vec%0d", i),
                    64'(got_mm), 64'(VEC[i].rb_bad));
            end else begin
                chk(pll_ctrl == 3'b001 && got_err == 1'b1, $sformatf("R6 timeout end vec%0d", i),
                    64'({got_err, pll_ctrl}), 64'({1'b1, 3'b001}));
                chk(t_done - t_pu >= LOCK_C && t_done - t_pu <= LOCK_C + 4,
                    $sformatf("R6 lock window vec%0d", i), 64'(t_done - t_pu), 64'(LOCK_C));
            end
        end

        // R8: prepare while powered
        run_op(1, VEC[3], -1, '0);
        chk(t_done == 1 && nev == 0 && pll_ctrl == 3'b011, "R8 prepare no-op",
            64'({t_done[7:0], 8'(nev), pll_ctrl}), 64'({8'd1, 8'd0, 3'b011}));

        // R10: unprepare clears only power-up
        run_op(2, VEC[3], -1, '0);
        chk(pll_ctrl == 3'b010 && nev == 1, "R10 unprepare", 64'({8'(nev), pll_ctrl}),
            64'({8'd1, 3'b010}));

        // R9: cold prepare with lock, output already on
        s = pll_ctrl;
        run_op(1, VEC[3], -1, '0);
        exp_prep(s, 1'b1);
        cmp_events("R9 prepare with lock order");
        chk(pll_ctrl == 3'b011 && got_err == 1'b0, "R9 prepare end", 64'({got_err, pll_ctrl}),
            64'(3'b011));

        // R11: commands injected while busy are ignored
        s = pll_ctrl;
        run_op(0, VEC[0], 20, VEC[1]);
        exp_reprog(s, 1'b1);
        cmp_events("R11 sequence undisturbed");
        chk_regs(VEC[0], "R11 fields kept");
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && pll_ctrl == 3'b011, "R11 no late command", 64'({busy, pll_ctrl}),
            64'(3'b011));

        // R13: simultaneous commands, reprogram wins
        s = pll_ctrl;
        run_op(3, VEC[3], -1, '0);
        exp_reprog(s, 1'b1);
        cmp_events("R13 reprogram priority order");
        chk_regs(VEC[3], "R13 reprogram priority fields");

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule